// File: doc/BRIEF.md
# Direct-Mapped Byte Read Cache

This block sits between a byte-wide requester and a slower block memory. It answers byte reads on 12-bit physical addresses. It holds sixteen lines, each with one 4-byte block, and every set has exactly one line. Each address is split into three fields. The two lowest bits pick a byte inside the block. The next four bits pick the line, so neighbouring blocks land in different lines. The top six bits are stored as the tag and compared on every lookup.

When the chosen line is valid and its tag matches, the byte comes back on the cycle after the request is accepted, flagged as a hit. When either test fails, the cache stops accepting requests. It asks the memory port for the whole block, writes that block into the line and replaces whatever the line held before. It then returns the requested byte, flagged as a miss.

A separate preload port writes a complete line (tag and block) directly. Test setups use it to place known contents in the cache.

Top module: `dmc_top`

## Requirements
- R1: Address bits [1:0] are the byte offset, bits [5:2] the line index and bits [11:6] the tag. On a miss, `mem_addr` carries request address bits [11:2].
- R2: Reset clears every valid bit, so the first read of any address after reset is a miss.
- R3: A read is accepted on a rising edge where `req_valid` and `req_ready` are both high. When the indexed line is valid and its tag matches, `resp_valid` and `resp_hit` are both high on the very next cycle, for exactly one cycle.
- R4: The returned byte is block bits [8*k+7 : 8*k], where k is the offset. Byte 0 is the least significant byte of the 32-bit block.
- R5: After a miss is accepted, `req_ready` is low and `mem_req` is high. `mem_addr` holds steady until the rising edge at which `mem_ack` is high.
- R6: The cycle after the edge that samples `mem_ack`, `resp_valid` is high with `resp_hit` low. `resp_data` is the offset-selected byte of `mem_data`, and `req_ready` is high again.
- R7: A refill replaces the indexed line. A later read of the old tag at that index misses, and a later read of the new tag hits.
- R8: A preload (`fill_en` high at an edge while no refill is pending) marks the line at `fill_addr` bits [5:2] valid, with tag `fill_addr` bits [11:6] and block `fill_data`. A preload presented while a refill is pending is ignored.
- R9: When a read and a preload to the same line are accepted on the same edge, the read sees the line's contents from before the preload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Read request present |
| req_addr | input | 12 | Physical byte address of the read |
| req_ready | output | 1 | High when a request can be accepted |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_hit | output | 1 | 1 = served from a line, 0 = served after a refill |
| resp_data | output | 8 | Returned byte |
| mem_req | output | 1 | Block fetch pending |
| mem_addr | output | 10 | Block address of the fetch |
| mem_ack | input | 1 | Memory returns the block this cycle |
| mem_data | input | 32 | Fetched block, byte 0 in bits [7:0] |
| fill_en | input | 1 | Preload strobe |
| fill_addr | input | 12 | Address whose line and tag the preload writes |
| fill_data | input | 32 | Block written by the preload |

## Verification
The bench targets several corner cases, each with a distinct symptom when the design gets it wrong.

- **Neighbouring blocks and conflicting tags.** Neighbouring blocks must coexist, while two tags that share an index must evict each other. A cache that took its index from the wrong bits would keep the conflicting pair and lose the neighbours.
- **Preload during a refill.** A preload issued mid-refill must be dropped. A design that honoured it would later report a hit for a line that was never legally filled.
- **Read and preload on the same edge.** A read and a preload to the same line on one edge must see the old line. A design that forwarded the new contents would return the wrong tag's byte.
- **Top of the address space.** Address 0xFFF checks that the highest offset and the all-ones block address reach the memory port intact.
- **Reset in the middle of a run.** Valid lines must all be forgotten.

Memory latencies are randomised, so stall lengths vary from run to run.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_FETCH = 1'b1
  } dmc_state_e;
endpackage

// File: rtl/dmc_byte_sel.sv
module dmc_byte_sel #(
  parameter int OFS_W  = 2,
  parameter int BYTE_W = 8,
  localparam int NBYTE = 1 << OFS_W,
  localparam int BLK_W = BYTE_W * NBYTE
) (
  input  logic [BLK_W-1:0]  blk_i,
  input  logic [OFS_W-1:0]  ofs_i,
  output logic [BYTE_W-1:0] byte_o
);
  always_comb begin
    byte_o = '0;
    for (int k = 0; k < NBYTE; k++) begin
      if (ofs_i == OFS_W'(k)) byte_o = blk_i[k*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int IDX_W = 4,
  parameter int TAG_W = 6,
  localparam int LINES = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [TAG_W-1:0] rd_tag,
  output logic             hit_o,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag
);
  logic [LINES-1:0]       valid_vec;
  logic [LINES*TAG_W-1:0] tag_flat;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic             valid_r;
    logic [TAG_W-1:0] tag_r;
    logic             line_we;

    assign line_we = wr_en && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       valid_r <= 1'b0;
      else if (line_we) valid_r <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (line_we) tag_r <= wr_tag;
    end

    assign valid_vec[i]                 = valid_r;
    assign tag_flat[i*TAG_W +: TAG_W]   = tag_r;
  end

  assign hit_o = valid_vec[rd_idx] && (tag_flat[rd_idx*TAG_W +: TAG_W] == rd_tag);

  // R2: no line is valid in the first cycle after reset
  a_r2_clear_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (valid_vec == '0));
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
  parameter int IDX_W  = 4,
  parameter int OFS_W  = 2,
  parameter int BYTE_W = 8,
  localparam int LINES = 1 << IDX_W,
  localparam int BLK_W = BYTE_W << OFS_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BLK_W-1:0]  wr_blk,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [OFS_W-1:0]  rd_ofs,
  output logic [BYTE_W-1:0] rd_byte
);
  logic [LINES*BLK_W-1:0] blk_flat;
  logic [BLK_W-1:0]       rd_blk;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic [BLK_W-1:0] blk_r;
    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == IDX_W'(i))) blk_r <= wr_blk;
    end
    assign blk_flat[i*BLK_W +: BLK_W] = blk_r;
  end

  assign rd_blk = blk_flat[rd_idx*BLK_W +: BLK_W];

  dmc_byte_sel #(.OFS_W(OFS_W), .BYTE_W(BYTE_W)) i_rd_sel (
    .blk_i  (rd_blk),
    .ofs_i  (rd_ofs),
    .byte_o (rd_byte)
  );
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int OFS_W  = 2,
  parameter int BYTE_W = 8,
  localparam int BLK_W  = BYTE_W << OFS_W,
  localparam int BLKA_W = ADDR_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  input  logic              lookup_hit,
  input  logic [BYTE_W-1:0] lookup_byte,
  output logic              mem_req,
  output logic [BLKA_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [BLK_W-1:0]  mem_data,
  output logic              refill_en,
  output logic [ADDR_W-1:0] refill_addr,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [BYTE_W-1:0] resp_data
);
  dmc_state_e        state_q, state_d;
  logic [ADDR_W-1:0] pend_q;
  logic              pend_en;
  logic              accept, ack;
  logic              rv_d, rh_d;
  logic [BYTE_W-1:0] rd_d, mem_byte;

  dmc_byte_sel #(.OFS_W(OFS_W), .BYTE_W(BYTE_W)) i_mem_sel (
    .blk_i  (mem_data),
    .ofs_i  (pend_q[OFS_W-1:0]),
    .byte_o (mem_byte)
  );

  always_comb begin
    accept  = (state_q == ST_IDLE) && req_valid;
    ack     = (state_q == ST_FETCH) && mem_ack;
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (accept && !lookup_hit) state_d = ST_FETCH;
      ST_FETCH: if (mem_ack)               state_d = ST_IDLE;
      default:                             state_d = ST_IDLE;
    endcase
    pend_en = accept;
    rv_d    = (accept && lookup_hit) || ack;
    rh_d    = accept && lookup_hit;
    rd_d    = ack ? mem_byte : lookup_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
    end else begin
      state_q    <= state_d;
      resp_valid <= rv_d;
      resp_hit   <= rh_d;
    end
  end

  always_ff @(posedge clk) begin
    if (pend_en) pend_q    <= req_addr;
    if (rv_d)    resp_data <= rd_d;
  end

  assign req_ready   = (state_q == ST_IDLE);
  assign mem_req     = (state_q == ST_FETCH);
  assign mem_addr    = pend_q[ADDR_W-1:OFS_W];
  assign refill_en   = ack;
  assign refill_addr = pend_q;

  // R5: fetch request and its address are held until acknowledged
  a_r5_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
  // R6: a miss response follows an acknowledged fetch
  a_r6_miss_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_hit) |-> $past(mem_req && mem_ack));
endmodule

// File: rtl/dmc_top.sv
module dmc_top #(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 4,
  parameter int OFS_W  = 2,
  parameter int BYTE_W = 8,
  localparam int TAG_W  = ADDR_W - IDX_W - OFS_W,
  localparam int BLK_W  = BYTE_W << OFS_W,
  localparam int BLKA_W = ADDR_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [BYTE_W-1:0] resp_data,
  output logic              mem_req,
  output logic [BLKA_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [BLK_W-1:0]  mem_data,
  input  logic              fill_en,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [BLK_W-1:0]  fill_data
);
  logic [1:0]        rst_pipe;
  logic              rst_s;
  logic              lookup_hit;
  logic [BYTE_W-1:0] lookup_byte;
  logic              refill_en;
  logic [ADDR_W-1:0] refill_addr;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [BLK_W-1:0]  wr_blk;
  logic              fill_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  // refill and preload never coincide: preload is only taken while idle
  assign fill_ok = fill_en && req_ready;
  assign wr_en   = refill_en || fill_ok;
  assign wr_addr = refill_en ? refill_addr : fill_addr;
  assign wr_blk  = refill_en ? mem_data    : fill_data;

  dmc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) i_tags (
    .clk    (clk),
    .rst_n  (rst_s),
    .rd_idx (req_addr[OFS_W +: IDX_W]),
    .rd_tag (req_addr[ADDR_W-1 -: TAG_W]),
    .hit_o  (lookup_hit),
    .wr_en  (wr_en),
    .wr_idx (wr_addr[OFS_W +: IDX_W]),
    .wr_tag (wr_addr[ADDR_W-1 -: TAG_W])
  );

  dmc_data_store #(.IDX_W(IDX_W), .OFS_W(OFS_W), .BYTE_W(BYTE_W)) i_data (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_idx  (wr_addr[OFS_W +: IDX_W]),
    .wr_blk  (wr_blk),
    .rd_idx  (req_addr[OFS_W +: IDX_W]),
    .rd_ofs  (req_addr[OFS_W-1:0]),
    .rd_byte (lookup_byte)
  );

  dmc_ctrl #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .BYTE_W(BYTE_W)) i_ctrl (
    .clk         (clk),
    .rst_n       (rst_s),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .req_ready   (req_ready),
    .lookup_hit  (lookup_hit),
    .lookup_byte (lookup_byte),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_ack     (mem_ack),
    .mem_data    (mem_data),
    .refill_en   (refill_en),
    .refill_addr (refill_addr),
    .resp_valid  (resp_valid),
    .resp_hit    (resp_hit),
    .resp_data   (resp_data)
  );

  // R3: an accepted hit is answered on the next cycle
  a_r3_hit_next_cycle: assert property (@(posedge clk) disable iff (!rst_s)
    (req_valid && req_ready && lookup_hit) |=> (resp_valid && resp_hit));
  // R3: a hit response only follows an accepted request
  a_r3_hit_has_request: assert property (@(posedge clk) disable iff (!rst_s)
    (resp_valid && resp_hit) |-> $past(req_valid && req_ready));
  // R5: an accepted miss stalls and starts a fetch
  a_r5_miss_stalls: assert property (@(posedge clk) disable iff (!rst_s)
    (req_valid && req_ready && !lookup_hit) |=> (mem_req && !req_ready && !resp_valid));
  // R8: a preload offered during a refill writes nothing
  a_r8_no_fill_when_busy: assert property (@(posedge clk) disable iff (!rst_s)
    (fill_en && mem_req) |-> (wr_en == mem_ack));
endmodule

// File: tb/test_dmc_top.sv
module test_dmc_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [11:0] req_addr;
  logic        req_ready;
  logic        resp_valid;
  logic        resp_hit;
  logic [7:0]  resp_data;
  logic        mem_req;
  logic [9:0]  mem_addr;
  logic        mem_ack;
  logic [31:0] mem_data;
  logic        fill_en;
  logic [11:0] fill_addr;
  logic [31:0] fill_data;

  int n_chk = 0;
  int n_err = 0;
  int lat   = 1;
  int wcnt  = 0;

  always #4 clk = ~clk;

  dmc_top i_dmc_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .resp_valid(resp_valid), .resp_hit(resp_hit),
    .resp_data(resp_data), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_data(mem_data), .fill_en(fill_en),
    .fill_addr(fill_addr), .fill_data(fill_data)
  );

  function automatic logic [31:0] pat(input logic [9:0] b);
    return (32'(b) * 32'h01030507) ^ 32'h9E3779B9;
  endfunction

  function automatic logic [7:0] byte_of(input logic [31:0] w, input logic [1:0] k);
    return w[8*k +: 8];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: line table, pending miss, expected response
  bit          m_v [16];
  logic [5:0]  m_t [16];
  logic [31:0] m_d [16];
  bit          m_busy;
  logic [11:0] m_pend;
  bit          e_rv, e_rh;
  logic [7:0]  e_rd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) m_v[i] = 1'b0;
      m_busy = 1'b0;
      e_rv   = 1'b0;
      e_rh   = 1'b0;
    end else begin
      e_rv = 1'b0;
      e_rh = 1'b0;
      if (m_busy) begin
        if (mem_ack) begin
          m_v[m_pend[5:2]] = 1'b1;
          m_t[m_pend[5:2]] = m_pend[11:6];
          m_d[m_pend[5:2]] = mem_data;
          e_rv   = 1'b1;
          e_rd   = byte_of(mem_data, m_pend[1:0]);
          m_busy = 1'b0;
        end
      end else begin
        if (req_valid) begin
          if (m_v[req_addr[5:2]] && m_t[req_addr[5:2]] == req_addr[11:6]) begin
            e_rv = 1'b1;
            e_rh = 1'b1;
            e_rd = byte_of(m_d[req_addr[5:2]], req_addr[1:0]);
          end else begin
            m_busy = 1'b1;
            m_pend = req_addr;
          end
        end
        if (fill_en) begin
          m_v[fill_addr[5:2]] = 1'b1;
          m_t[fill_addr[5:2]] = fill_addr[11:6];
          m_d[fill_addr[5:2]] = fill_data;
        end
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(req_ready == !m_busy, "R5", 32'(req_ready), 32'(!m_busy));
      chk(mem_req == m_busy, "R5", 32'(mem_req), 32'(m_busy));
      if (m_busy) chk(mem_addr == m_pend[11:2], "R1", 32'(mem_addr), 32'(m_pend[11:2]));
      chk(resp_valid == e_rv, "R3", 32'(resp_valid), 32'(e_rv));
      if (e_rv) begin
        chk(resp_hit == e_rh, "R6", 32'(resp_hit), 32'(e_rh));
        chk(resp_data == e_rd, "R4", 32'(resp_data), 32'(e_rd));
      end
    end
  end

  // memory responder
  always @(negedge clk) begin
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      if (wcnt >= lat) begin
        mem_ack  = 1'b1;
        mem_data = pat(mem_addr);
        wcnt     = 0;
      end else wcnt++;
    end
  end

  task automatic rd(input logic [11:0] a, output logic h, output logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!resp_valid) @(negedge clk);
    h = resp_hit;
    d = resp_data;
  endtask

  task automatic fill(input logic [11:0] a, input logic [31:0] w);
    @(negedge clk);
    fill_en   = 1'b1;
    fill_addr = a;
    fill_data = w;
    @(negedge clk);
    fill_en   = 1'b0;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic eh, input logic [7:0] ed, input string tag);
    logic h;
    logic [7:0] d;
    rd(a, h, d);
    chk(h == eh, tag, 32'(h), 32'(eh));
    chk(d == ed, tag, 32'(d), 32'(ed));
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL R5 watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; mem_ack = 1'b0;
    mem_data = '0; fill_en = 1'b0; fill_addr = '0; fill_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready == 1'b1, "R2", 32'(req_ready), 1);
    chk(resp_valid == 1'b0, "R2", 32'(resp_valid), 0);
    chk(mem_req == 1'b0, "R2", 32'(mem_req), 0);

    // R2 / R6: first access misses and returns the fetched byte
    rd_chk(12'h0D4, 1'b0, byte_of(pat(10'h035), 2'd0), "R6");
    // R3 / R4: remaining bytes of the block hit
    rd_chk(12'h0D5, 1'b1, byte_of(pat(10'h035), 2'd1), "R4");
    rd_chk(12'h0D6, 1'b1, byte_of(pat(10'h035), 2'd2), "R4");
    rd_chk(12'h0D7, 1'b1, byte_of(pat(10'h035), 2'd3), "R3");
    // R1: neighbouring block uses a different line
    rd_chk(12'h0D8, 1'b0, byte_of(pat(10'h036), 2'd0), "R1");
    rd_chk(12'h0D4, 1'b1, byte_of(pat(10'h035), 2'd0), "R1");
    // R7: same index, other tag evicts
    rd_chk(12'h114, 1'b0, byte_of(pat(10'h045), 2'd0), "R7");
    rd_chk(12'h0D4, 1'b0, byte_of(pat(10'h035), 2'd0), "R7");
    // R8: preload then hit, offset 3
    fill(12'hA28, 32'h3BDA1593);
    rd_chk(12'hA2B, 1'b1, 8'h3B, "R8");
    // R1: top of the address space
    rd_chk(12'hFFF, 1'b0, byte_of(pat(10'h3FF), 2'd3), "R1");
    rd_chk(12'hFFC, 1'b1, byte_of(pat(10'h3FF), 2'd0), "R4");

    // R8: preload while a refill is pending is dropped
    lat = 6;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 12'h400;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R5", 32'(req_ready), 0);
    fill(12'h7F0, 32'h11223344);
    while (!resp_valid) @(negedge clk);
    lat = 1;
    rd_chk(12'h7F0, 1'b0, byte_of(pat(10'h1FC), 2'd0), "R8");

    // R9: read and preload to one line on the same edge
    fill(12'h30C, 32'hA1B2C3D4);
    @(negedge clk);
    req_valid = 1'b1; req_addr = 12'h30D;
    fill_en = 1'b1; fill_addr = 12'h04C; fill_data = 32'h55667788;
    @(negedge clk);
    req_valid = 1'b0; fill_en = 1'b0;
    chk(resp_valid == 1'b1, "R9", 32'(resp_valid), 1);
    chk(resp_hit == 1'b1, "R9", 32'(resp_hit), 1);
    chk(resp_data == 8'hC3, "R9", 32'(resp_data), 32'hC3);
    rd_chk(12'h04C, 1'b1, 8'h88, "R9");

    // R2: reset mid-run forgets every line
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd_chk(12'hFFC, 1'b0, byte_of(pat(10'h3FF), 2'd0), "R2");

    // mixed traffic, checked by the reference every cycle
    for (int n = 0; n < 400; n++) begin
      logic h;
      logic [7:0] d;
      logic [11:0] a;
      a   = {4'b0, 2'($urandom_range(0, 3)), 4'($urandom_range(0, 15)), 2'($urandom_range(0, 3))};
      lat = $urandom_range(0, 3);
      if ($urandom_range(0, 3) == 0) fill(a, $urandom);
      else rd(a, h, d);
    end

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule